// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 32,768 bytes. The RAM has a 15-bit address, an 8-bit data bus shared by both directions, and three active-low strobes: chip select, output enable and write enable. The host presents one read or write at a time on a request/acknowledge port. The sequencer then steps the RAM strobes through a timed series of phases and pulses an acknowledge when the access is complete. For reads, the acknowledge comes with the captured byte.

Every RAM timing limit is a nanosecond parameter. Each limit is converted to a whole number of clock cycles by ceiling division against the clock period. Writes always keep output enable high, so the short write pulse applies. The sequencer holds back its own bus drive until the RAM's outputs have had time to float after a read, and it adds one idle cycle before a read that follows a write. The bidirectional bus is exposed as separate out, enable and in vectors, which the pad ring combines.

Top module: `async_sram_ctrl`

## Requirements
All cycle counts below are for the default parameters (10 ns clock, 70 ns grade). They give an access length of 7, a write pulse of 5, a write hold of 1 and a turnaround of 3.
- R1: During and after reset, with no request, memCsN, memOeN and memWeN are 1, and memDqEn and hostAck are 0.
- R2: A read drives memCsN=0 and memOeN=0 with memWeN=1 and memDqEn=0 for exactly 7 consecutive cycles. Output enable is never low without chip select. The byte present on memDqIn in the last of those cycles is returned on hostRdata.
- R3: hostAck is high for exactly one cycle. That cycle directly follows the release of the RAM strobes, and hostRdata holds the read byte in it. A request still held during the acknowledge cycle starts its access only in the cycle after the acknowledge.
- R4: A write holds memOeN=1 and memCsN=0 for its whole length. It starts with at least one cycle in which memWeN=1 and memDqEn=0. memWeN=0 then lasts exactly 5 cycles. memDqEn=1 with memDqOut equal to the request byte lasts from the first low write-enable cycle through 1 hold cycle after memWeN rises.
- R5: While memCsN is low, memAddr equals the address of the current request and does not change.
- R6: After memOeN rises at the end of a read, memDqEn does not rise until 3 cycles later. A write following a read has its setup phase stretched to meet this.
- R7: memDqEn is never 1 in a cycle where memOeN is 0.
- R8: A read whose previous access was a write has one extra cycle with all strobes high between acceptance and the start of the read. This holds even when idle cycles separate the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request, held until hostAck |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 15 | Request address |
| hostWdata | input | 8 | Write byte |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 8 | Captured read byte |
| memCsN | output | 1 | RAM chip select, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memAddr | output | 15 | RAM address |
| memDqOut | output | 8 | Byte driven toward the RAM |
| memDqEn | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 8 | Byte received from the RAM bus |

## Verification
The hardest situations to reach are the two direction changes on the shared bus with no slack between them. One is a write issued in the very acknowledge cycle of a read, where the turnaround count rather than the setup minimum decides when the drive turns on. The other is a read issued right after a write, which must pick up the extra idle cycle. The stimulus chains requests back to back by raising the next request in the acknowledge cycle, and also separates some pairs with idle gaps, so both cases occur with the turnaround timer partly and fully expired. The RAM model in the bench returns a junk pattern until the access time has elapsed, so a capture taken even one cycle early shows up as wrong data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_RACC,
    S_WSET,
    S_WPUL,
    S_WHOLD,
    S_DONE
  } seqState_t;

  // Strobes from control to datapath; pin fields are next-cycle pin levels
  typedef struct packed {
    logic load;
    logic capture;
    logic csN;
    logic oeN;
    logic weN;
    logic dqEn;
  } seqStrobes_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (load)          cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ACC_CYC   = 7,
  parameter int PULSE_CYC = 5,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 3,
  parameter int CNT_W     = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWrite,
  output logic        hostAck,
  output seqStrobes_t strb
);

  localparam int NUM_TMR = 4;
  localparam int T_ACC   = 0;
  localparam int T_PUL   = 1;
  localparam int T_HLD   = 2;
  localparam int T_TRN   = 3;

  seqState_t state, stateD;
  logic      lastWr;
  logic [NUM_TMR-1:0] tLoad, tZero;
  logic [CNT_W-1:0]   tVal [NUM_TMR];

  assign tVal[T_ACC] = CNT_W'(ACC_CYC - 1);
  assign tVal[T_PUL] = CNT_W'(PULSE_CYC - 1);
  assign tVal[T_HLD] = CNT_W'(HOLD_CYC - 1);
  assign tVal[T_TRN] = CNT_W'(TURN_CYC - 1);

  // One down-counter per phase
  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_timer
      seq_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rstN    (rstN),
        .load    (tLoad[i]),
        .loadVal (tVal[i]),
        .zero    (tZero[i])
      );
    end
  endgenerate

  always_comb begin
    stateD = state;
    unique case (state)
      S_IDLE:  if (hostReq) begin
                 if (hostWrite)   stateD = S_WSET;
                 else if (lastWr) stateD = S_TURN;
                 else             stateD = S_RACC;
               end
      S_TURN:  stateD = S_RACC;
      S_RACC:  if (tZero[T_ACC]) stateD = S_DONE;
      S_WSET:  if (tZero[T_TRN]) stateD = S_WPUL;
      S_WPUL:  if (tZero[T_PUL]) stateD = S_WHOLD;
      S_WHOLD: if (tZero[T_HLD]) stateD = S_DONE;
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_comb begin
    tLoad[T_ACC] = (stateD == S_RACC)  && (state != S_RACC);
    tLoad[T_PUL] = (stateD == S_WPUL)  && (state != S_WPUL);
    tLoad[T_HLD] = (stateD == S_WHOLD) && (state != S_WHOLD);
    // turnaround window opens on the edge that raises output enable
    tLoad[T_TRN] = (state == S_RACC)   && (stateD != S_RACC);
  end

  always_comb begin
    strb.load    = (state == S_IDLE) && hostReq;
    strb.capture = (state == S_RACC) && tZero[T_ACC];
    strb.csN     = !(stateD inside {S_RACC, S_WSET, S_WPUL, S_WHOLD});
    strb.oeN     = (stateD != S_RACC);
    strb.weN     = (stateD != S_WPUL);
    strb.dqEn    = (stateD inside {S_WPUL, S_WHOLD});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      lastWr <= 1'b0;
    end else begin
      state <= stateD;
      if (state == S_WHOLD && stateD == S_DONE) lastWr <= 1'b1;
      else if (state == S_RACC && stateD == S_DONE) lastWr <= 1'b0;
    end
  end

  assign hostAck = (state == S_DONE);

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  // R3
  no_accept_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> (state == S_IDLE));

  // R8
  turn_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |=> (state == S_RACC));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 5,
  parameter int TURN_CYC  = 3,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqEn,
  input  logic [DATA_W-1:0] memDqIn
);

  // Registered RAM strobes: no decode glitches reach the pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCsN  <= 1'b1;
      memOeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqEn <= 1'b0;
    end else begin
      memCsN  <= strb.csN;
      memOeN  <= strb.oeN;
      memWeN  <= strb.weN;
      memDqEn <= strb.dqEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDqOut  <= '0;
      hostRdata <= '0;
    end else begin
      if (strb.load) begin
        memAddr  <= hostAddr;
        memDqOut <= hostWdata;
      end
      if (strb.capture) hostRdata <= memDqIn;
    end
  end

  // Checker-side counters
  logic [CNT_W-1:0] weLowCnt, oeHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= '1;
    end else begin
      if (memWeN)                weLowCnt <= '0;
      else if (weLowCnt != '1)   weLowCnt <= weLowCnt + 1'b1;
      if (!memOeN)               oeHighCnt <= '0;
      else if (oeHighCnt != '1)  oeHighCnt <= oeHighCnt + 1'b1;
    end
  end

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqEn && !memOeN));

  // R4
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCsN && memDqEn));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= CNT_W'(PULSE_CYC)));

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqEn) |-> (oeHighCnt >= CNT_W'(TURN_CYC)));

  // R2
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCsN);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int AA_NS  = 70,   // address to data
  parameter int ACS_NS = 70,   // select to data
  parameter int AOE_NS = 35,   // output enable to data
  parameter int WP_NS  = 50,   // write pulse
  parameter int CW_NS  = 60,   // select to end of write
  parameter int AW_NS  = 60,   // address to end of write
  parameter int DW_NS  = 30,   // data setup to end of write
  parameter int WC_NS  = 70,   // write cycle
  parameter int OHZ_NS = 25    // outputs float after release
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqEn,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int ACC_CYC = imax(1, imax(cdiv(AA_NS, CLK_NS),
                                imax(cdiv(ACS_NS, CLK_NS), cdiv(AOE_NS, CLK_NS))));
  // one setup cycle already carries select and address
  localparam int PULSE_CYC = imax(1, imax(imax(cdiv(WP_NS, CLK_NS), cdiv(DW_NS, CLK_NS)),
                                  imax(cdiv(CW_NS, CLK_NS) - 1, cdiv(AW_NS, CLK_NS) - 1)));
  localparam int HOLD_CYC  = imax(1, cdiv(WC_NS, CLK_NS) - 1 - PULSE_CYC);
  localparam int TURN_CYC  = imax(1, cdiv(OHZ_NS, CLK_NS));
  localparam int MAX_CYC   = imax(imax(ACC_CYC, PULSE_CYC), imax(HOLD_CYC, TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqStrobes_t strb;

  seq_ctrl #(
    .ACC_CYC   (ACC_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostAck   (hostAck),
    .strb      (strb)
  );

  seq_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .memCsN    (memCsN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memAddr   (memAddr),
    .memDqOut  (memDqOut),
    .memDqEn   (memDqEn),
    .memDqIn   (memDqIn)
  );

endmodule

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_CYC    = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PULSE_CYC  = (50 + CLK_PERIOD - 1) / CLK_PERIOD - 0;
  localparam int HOLD_CYC   = 1;
  localparam int TURN_CYC   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostReq, hostWrite;
  logic [14:0] hostAddr;
  logic [7:0]  hostWdata, hostRdata;
  logic        hostAck;
  logic        memCsN, memOeN, memWeN, memDqEn;
  logic [14:0] memAddr;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hEE;

  int tests = 0;
  int fails = 0;
  int sIdx  = 0;
  int lastOeRise = -1000;
  bit inDone = 0;
  bit lastWr = 0;
  int rdActive = 0;
  logic [7:0] ramArr [int];
  logic [7:0] expMem [int];

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_sram_ctrl u0 (
    .clk, .rstN, .hostReq, .hostWrite, .hostAddr, .hostWdata,
    .hostAck, .hostRdata, .memCsN, .memOeN, .memWeN, .memAddr,
    .memDqOut, .memDqEn, .memDqIn
  );

  // RAM model: data valid only once the access time has elapsed
  always @(posedge clk)
    rdActive <= (!memCsN && !memOeN && memWeN) ? rdActive + 1 : 0;

  always @(negedge clk) begin
    if (!memCsN && !memWeN && memDqEn) ramArr[int'(memAddr)] = memDqOut;
    if (!memCsN && !memOeN && rdActive >= ACC_CYC - 1)
      memDqIn <= ramArr.exists(int'(memAddr)) ? ramArr[int'(memAddr)] : 8'h00;
    else
      memDqIn <= 8'hEE;
  end

  task automatic step();
    @(negedge clk);
    sIdx++;
  endtask

  task automatic expectPins(string req, logic cs, logic oe, logic we, logic en, logic ack);
    tests++;
    if ({memCsN, memOeN, memWeN, memDqEn, hostAck} !== {cs, oe, we, en, ack}) begin
      fails++;
      $display("FAIL %s: cs/oe/we/en/ack = %b expected %b at sample %0d", req,
               {memCsN, memOeN, memWeN, memDqEn, hostAck}, {cs, oe, we, en, ack}, sIdx);
    end
  endtask

  task automatic expectVal(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s = %0h expected %0h at sample %0d", req, what, act, exp, sIdx);
    end
  endtask

  task automatic idleGap(int n);
    hostReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      expectPins("R1 idle", 1, 1, 1, 0, 0);
    end
    inDone = 0;
  endtask

  task automatic doRead(logic [14:0] a);
    int expD;
    expD = expMem.exists(int'(a)) ? int'(expMem[int'(a)]) : 0;
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = a;
    if (inDone) begin
      step();
      expectPins("R3 no start in ack cycle", 1, 1, 1, 0, 0);
    end
    step();
    if (lastWr) begin
      expectPins("R8 idle before read after write", 1, 1, 1, 0, 0);
      step();
    end
    for (int i = 0; i < ACC_CYC; i++) begin
      if (i > 0) step();
      expectPins("R2 read strobes", 0, 0, 1, 0, 0);
      expectVal("R5 read address", "memAddr", int'(memAddr), int'(a));
    end
    step();
    expectPins("R3 read ack", 1, 1, 1, 0, 1);
    expectVal("R2 read data", "hostRdata", int'(hostRdata), expD);
    lastOeRise = sIdx;
    hostReq = 1'b0;
    inDone = 1; lastWr = 0;
  endtask

  task automatic doWrite(logic [14:0] a, logic [7:0] d);
    int nSet;
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    if (inDone) begin
      step();
      expectPins("R3 no start in ack cycle", 1, 1, 1, 0, 0);
    end
    step();
    nSet = lastOeRise + TURN_CYC - sIdx;
    if (nSet < 1) nSet = 1;
    for (int i = 0; i < nSet; i++) begin
      if (i > 0) step();
      expectPins("R6 write setup", 0, 1, 1, 0, 0);
      expectVal("R5 write address", "memAddr", int'(memAddr), int'(a));
    end
    for (int i = 0; i < PULSE_CYC; i++) begin
      step();
      expectPins("R4 write pulse", 0, 1, 0, 1, 0);
      expectVal("R4 write data", "memDqOut", int'(memDqOut), int'(d));
      if (i == 0) begin
        tests++;
        if (sIdx - lastOeRise < TURN_CYC) begin
          fails++;
          $display("FAIL R6 drive too early: %0d cycles after OE rose, expected >= %0d",
                   sIdx - lastOeRise, TURN_CYC);
        end
      end
    end
    for (int i = 0; i < HOLD_CYC; i++) begin
      step();
      expectPins("R4 write hold", 0, 1, 1, 1, 0);
      expectVal("R5 hold address", "memAddr", int'(memAddr), int'(a));
    end
    step();
    expectPins("R3 write ack", 1, 1, 1, 0, 1);
    expMem[int'(a)] = d;
    hostReq = 1'b0;
    inDone = 1; lastWr = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; hostReq = 1'b0; hostWrite = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(negedge clk);
    expectPins("R1 in reset", 1, 1, 1, 0, 0);
    rstN = 1'b1;
    idleGap(2);

    doRead(15'h0000);                // unwritten location
    doWrite(15'h1234, 8'hA5);        // write right after read: turnaround
    doWrite(15'h7FFF, 8'h3C);        // write after write
    doRead(15'h7FFF);                // read right after write
    doRead(15'h1234);                // read after read
    idleGap(5);
    doWrite(15'h0000, 8'h5A);        // from idle, turnaround long expired
    idleGap(2);
    doRead(15'h0000);                // read after write across a gap
    doRead(15'h0001);
    idleGap(1);
    doWrite(15'h0001, 8'hFF);        // write one cycle past a read ack
    for (int i = 0; i < 8; i++) doWrite(15'(i * 16'h0F01), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) doRead(15'(i * 16'h0F01));
    doRead(15'h0001);
    idleGap(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule